// File: doc/BRIEF.md
# Chained Up/Down Timer Pair

Two up/down counters of the same width are chained through a one-bit toggle latch. The lower (core) counter advances in one of three ways: on a divided-down system clock, on that divided clock only while a gate input sits at a chosen level, or on rising edges of an external count input. Whenever the core counter wraps in either direction, the latch flips. The upper (auxiliary) counter advances on a selected edge of that latch. With both edges selected, the pair is a 32-bit counter. With only one edge selected, the latch becomes the middle bit of a 33-bit counter.

Each half has its own run enable and its own count direction, so mixed configurations are allowed. Examples are a core counting down while the auxiliary counts up, or the reverse. Software can load either counter and can force the latch. Each counter raises a one-cycle interrupt pulse when it wraps. The latch edge detector is a two-state machine. Its states are `TL_LOW` and `TL_HIGH`, and it tracks a registered copy of the latch. The transition *rise seen* goes from `TL_LOW` to `TL_HIGH`. The transition *fall seen* goes from `TL_HIGH` to `TL_LOW`. In every other cycle the machine holds its state. An edge is reported only in the cycle in which the latch differs from the state.

Top module: `chained_timer_pair`

## Requirements
- R1: While `rst_n` is low, both counters, the latch and both interrupt outputs are 0.
- R2: A core count event moves `core_val` up by 1 (`core_up`=1) or down by 1 (`core_up`=0). Going up from 16'hFFFF gives 0, and going down from 0 gives 16'hFFFF. Either wrap makes `core_irq` high for exactly the cycle following the edge that wrapped.
- R3: Every core wrap inverts `tl_q` on the same clock edge that updates `core_val`.
- R4: With `edge_sel`=2'b10 or 2'b11 (any edge), the auxiliary counter steps once for each latch change. The step lands on the clock edge after the edge that changed the latch.
- R5: With `edge_sel`=2'b00 (rising only) or 2'b01 (falling only), the auxiliary counter steps only on that latch transition. It therefore moves once per two core wraps.
- R6: `aux_up` sets the auxiliary direction independently of `core_up`. The auxiliary counter wraps the same way as the core counter (16'hFFFF to 0 going up, 0 to 16'hFFFF going down). Each auxiliary wrap makes `aux_irq` high for one cycle.
- R7: With `core_mode`=2'b00 (timer) and `core_run` high, the core counter steps once every 2^(`presc_sel`+3) clocks. The first step comes on the 2^(`presc_sel`+3)-th clock edge after `core_run` rises. Lowering `core_run` restarts the division.
- R8: With `core_mode`=2'b01 (gated), the core counter steps on a divided-clock tick only while `gate_in` equals `gate_lvl`.
- R9: With `core_mode`=2'b10 (counter) and `core_run` high, each 0-to-1 change of `cnt_in` between two clock samples is one core count event. The counter updates on the edge that first sees `cnt_in` high. `core_mode`=2'b11 never counts.
- R10: `core_wr` loads `core_wdata` into the core counter and beats any count event in the same cycle. No wrap, latch flip or `core_irq` results from that event.
- R11: `aux_wr` loads `aux_wdata` into the auxiliary counter and beats an auxiliary step in the same cycle. No `aux_irq` results from that step.
- R12: `tl_wr` loads `tl_wdata` into the latch and beats a core wrap in the same cycle. A latch change caused by this write counts as a latch edge for the auxiliary counter.
- R13: While `aux_run` is low, the auxiliary counter ignores latch edges. While `core_run` is low, the core counter ignores every count source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_run | input | 1 | Core counter enable |
| aux_run | input | 1 | Auxiliary counter enable |
| core_up | input | 1 | Core direction, 1 = up |
| aux_up | input | 1 | Auxiliary direction, 1 = up |
| core_mode | input | 2 | 00 timer, 01 gated, 10 counter, 11 halt |
| presc_sel | input | 3 | Clock divider select, ratio 2^(n+3) |
| gate_lvl | input | 1 | Gate level that allows counting |
| gate_in | input | 1 | Gate input for gated mode |
| cnt_in | input | 1 | External count input for counter mode |
| edge_sel | input | 2 | Latch edge: 00 rise, 01 fall, 1x both |
| core_wr | input | 1 | Load strobe for the core counter |
| core_wdata | input | 16 | Core load value |
| aux_wr | input | 1 | Load strobe for the auxiliary counter |
| aux_wdata | input | 16 | Auxiliary load value |
| tl_wr | input | 1 | Load strobe for the toggle latch |
| tl_wdata | input | 1 | Toggle latch load value |
| core_val | output | 16 | Core counter value |
| aux_val | output | 16 | Auxiliary counter value |
| tl_q | output | 1 | Toggle latch state |
| core_irq | output | 1 | Core wrap pulse |
| aux_irq | output | 1 | Auxiliary wrap pulse |

## Verification
Three pairs of functions can fall in one cycle. A software load of a counter can meet a count event of that same counter. A latch load can meet the core wrap that would flip the latch. The bench provokes each pair on purpose. It pulses `cnt_in` in the cycle that carries `core_wr`. It raises `aux_wr` in the cycle right after a core wrap, when the auxiliary step is due. It issues `tl_wr` with the current latch value together with a wrapping pulse. A reference model built from the requirements predicts every cycle. A clash is judged correct when the loaded value appears and there is neither an interrupt nor a latch flip.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
    typedef enum logic [1:0] {
        MODE_TIMER   = 2'd0,
        MODE_GATED   = 2'd1,
        MODE_COUNTER = 2'd2,
        MODE_HALT    = 2'd3
    } core_mode_e;

    typedef enum logic [1:0] {
        EDGE_RISE  = 2'd0,
        EDGE_FALL  = 2'd1,
        EDGE_ANY   = 2'd2,
        EDGE_ANY_B = 2'd3
    } edge_sel_e;

    typedef enum logic {
        TL_LOW  = 1'b0,
        TL_HIGH = 1'b1
    } tl_state_e;
endpackage

// File: rtl/ctp_prescaler.sv
module ctp_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = (1 << SEL_W) + 2;
    localparam int SH_W  = $clog2(CNT_W + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic [SH_W-1:0]  shamt;

    always_comb begin
        shamt = SH_W'(sel) + SH_W'(3);
        limit = ~({CNT_W{1'b1}} << shamt);
        tick  = en && (cnt >= limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ctp_core_timer.sv
module ctp_core_timer
    import ctp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         up,
    input  core_mode_e   mode,
    input  logic         tick,
    input  logic         gate_lvl,
    input  logic         gate_in,
    input  logic         cnt_in,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         tl_wr,
    input  logic         tl_wdata,
    output logic [W-1:0] val,
    output logic         tl,
    output logic         irq
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic cnt_prev;
    logic cnt_rise;
    logic evt;
    logic wrap;

    always_comb begin
        cnt_rise = cnt_in && !cnt_prev;
        unique case (mode)
            MODE_TIMER:   evt = tick;
            MODE_GATED:   evt = tick && (gate_in == gate_lvl);
            MODE_COUNTER: evt = run && cnt_rise;
            MODE_HALT:    evt = 1'b0;
            default:      evt = 1'b0;
        endcase
        wrap = evt && !wr && (up ? (val == TOP) : (val == '0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val      <= '0;
            tl       <= 1'b0;
            irq      <= 1'b0;
            cnt_prev <= 1'b0;
        end else begin
            cnt_prev <= cnt_in;
            irq      <= wrap;
            if (wr) begin
                val <= wdata;
            end else if (evt) begin
                val <= up ? val + 1'b1 : val - 1'b1;
            end
            if (tl_wr) begin
                tl <= tl_wdata;
            end else if (wrap) begin
                tl <= ~tl;
            end
        end
    end
endmodule

// File: rtl/ctp_edge_fsm.sv
module ctp_edge_fsm
    import ctp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tl,
    input  logic      run,
    input  edge_sel_e sel,
    output logic      step
);
    tl_state_e state;
    tl_state_e state_nx;
    logic      rise_seen;
    logic      fall_seen;

    // state register: follows the latch one cycle behind
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TL_LOW;
        end else begin
            state <= state_nx;
        end
    end

    // transitions and outputs
    always_comb begin
        rise_seen = 1'b0;
        fall_seen = 1'b0;
        state_nx  = state;
        unique case (state)
            TL_LOW: begin
                if (tl) begin
                    rise_seen = 1'b1;
                    state_nx  = TL_HIGH;
                end
            end
            TL_HIGH: begin
                if (!tl) begin
                    fall_seen = 1'b1;
                    state_nx  = TL_LOW;
                end
            end
            default: state_nx = TL_LOW;
        endcase
        unique case (sel)
            EDGE_RISE: step = run && rise_seen;
            EDGE_FALL: step = run && fall_seen;
            default:   step = run && (rise_seen || fall_seen);
        endcase
    end
endmodule

// File: rtl/ctp_aux_timer.sv
module ctp_aux_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         up,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] val,
    output logic         irq
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic wrap;

    assign wrap = step && !wr && (up ? (val == TOP) : (val == '0));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val <= '0;
            irq <= 1'b0;
        end else begin
            irq <= wrap;
            if (wr) begin
                val <= wdata;
            end else if (step) begin
                val <= up ? val + 1'b1 : val - 1'b1;
            end
        end
    end
endmodule

// File: rtl/chained_timer_pair.sv
module chained_timer_pair
    import ctp_pkg::*;
#(
    parameter int W     = 16,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_run,
    input  logic             aux_run,
    input  logic             core_up,
    input  logic             aux_up,
    input  logic [1:0]       core_mode,
    input  logic [SEL_W-1:0] presc_sel,
    input  logic             gate_lvl,
    input  logic             gate_in,
    input  logic             cnt_in,
    input  logic [1:0]       edge_sel,
    input  logic             core_wr,
    input  logic [W-1:0]     core_wdata,
    input  logic             aux_wr,
    input  logic [W-1:0]     aux_wdata,
    input  logic             tl_wr,
    input  logic             tl_wdata,
    output logic [W-1:0]     core_val,
    output logic [W-1:0]     aux_val,
    output logic             tl_q,
    output logic             core_irq,
    output logic             aux_irq
);
    logic tick;
    logic aux_step;

    ctp_prescaler #(.SEL_W(SEL_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (core_run),
        .sel   (presc_sel),
        .tick  (tick)
    );

    ctp_core_timer #(.W(W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (core_run),
        .up       (core_up),
        .mode     (core_mode_e'(core_mode)),
        .tick     (tick),
        .gate_lvl (gate_lvl),
        .gate_in  (gate_in),
        .cnt_in   (cnt_in),
        .wr       (core_wr),
        .wdata    (core_wdata),
        .tl_wr    (tl_wr),
        .tl_wdata (tl_wdata),
        .val      (core_val),
        .tl       (tl_q),
        .irq      (core_irq)
    );

    ctp_edge_fsm u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .tl    (tl_q),
        .run   (aux_run),
        .sel   (edge_sel_e'(edge_sel)),
        .step  (aux_step)
    );

    ctp_aux_timer #(.W(W)) u_aux (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (aux_step),
        .up    (aux_up),
        .wr    (aux_wr),
        .wdata (aux_wdata),
        .val   (aux_val),
        .irq   (aux_irq)
    );
endmodule

// File: rtl/ctp_checker.sv
module ctp_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         core_run,
    input logic         aux_run,
    input logic         core_wr,
    input logic [W-1:0] core_wdata,
    input logic         aux_wr,
    input logic [W-1:0] aux_wdata,
    input logic         tl_wr,
    input logic         tl_wdata,
    input logic [W-1:0] core_val,
    input logic [W-1:0] aux_val,
    input logic         tl_q,
    input logic         core_irq,
    input logic         aux_irq
);
    a_r2_core_irq_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        core_irq |-> (core_val == '0 || core_val == {W{1'b1}}));

    a_r2_core_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        core_irq |=> !core_irq);

    a_r3_latch_flips: assert property (@(posedge clk) disable iff (!rst_n)
        core_irq |-> (tl_q != $past(tl_q)) || $past(tl_wr));

    a_r6_aux_irq_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        aux_irq |-> (aux_val == '0 || aux_val == {W{1'b1}}));

    a_r10_core_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        core_wr |=> (core_val == $past(core_wdata)) && !core_irq);

    a_r11_aux_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        aux_wr |=> (aux_val == $past(aux_wdata)) && !aux_irq);

    a_r12_latch_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        tl_wr |=> (tl_q == $past(tl_wdata)));

    a_r13_aux_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!aux_run && !aux_wr) |=> $stable(aux_val));

    a_r13_core_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_run && !core_wr) |=> $stable(core_val));
endmodule

bind chained_timer_pair ctp_checker #(.W(W)) u_ctp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_run   (core_run),
    .aux_run    (aux_run),
    .core_wr    (core_wr),
    .core_wdata (core_wdata),
    .aux_wr     (aux_wr),
    .aux_wdata  (aux_wdata),
    .tl_wr      (tl_wr),
    .tl_wdata   (tl_wdata),
    .core_val   (core_val),
    .aux_val    (aux_val),
    .tl_q       (tl_q),
    .core_irq   (core_irq),
    .aux_irq    (aux_irq)
);

// File: tb/chained_timer_pair_test.sv
module chained_timer_pair_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_run = 1'b0, aux_run = 1'b0, core_up = 1'b1, aux_up = 1'b1;
    logic [1:0]  core_mode = 2'd2;
    logic [2:0]  presc_sel = 3'd0;
    logic        gate_lvl = 1'b1, gate_in = 1'b0, cnt_in = 1'b0;
    logic [1:0]  edge_sel = 2'd2;
    logic        core_wr = 1'b0, aux_wr = 1'b0, tl_wr = 1'b0, tl_wdata = 1'b0;
    logic [15:0] core_wdata = '0, aux_wdata = '0;
    logic [15:0] core_val, aux_val;
    logic        tl_q, core_irq, aux_irq;

    always #10 clk = ~clk;

    chained_timer_pair uut (
        .clk(clk), .rst_n(rst_n), .core_run(core_run), .aux_run(aux_run),
        .core_up(core_up), .aux_up(aux_up), .core_mode(core_mode),
        .presc_sel(presc_sel), .gate_lvl(gate_lvl), .gate_in(gate_in),
        .cnt_in(cnt_in), .edge_sel(edge_sel), .core_wr(core_wr),
        .core_wdata(core_wdata), .aux_wr(aux_wr), .aux_wdata(aux_wdata),
        .tl_wr(tl_wr), .tl_wdata(tl_wdata), .core_val(core_val),
        .aux_val(aux_val), .tl_q(tl_q), .core_irq(core_irq), .aux_irq(aux_irq)
    );

    typedef struct {
        logic [15:0] core;
        logic [15:0] aux;
        logic        tl;
        logic        cirq;
        logic        airq;
        string       req;
    } exp_t;

    exp_t  exp_q[$];
    exp_t  got;
    string cur_req = "R1";
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    // reference model state
    logic [15:0] m_core = '0, m_aux = '0;
    logic        m_tl = 1'b0, m_tlq = 1'b0, m_cq = 1'b0, m_cirq = 1'b0, m_airq = 1'b0;
    int          m_pre = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // driver: predicts the next state from the requirements, pushes it
    task automatic cyc();
        int   lim;
        logic tick, evt, cwrap, rise, fall, step, awrap;
        logic [15:0] n_core, n_aux;
        logic        n_tl;
        exp_t e;
        lim   = (1 << (int'(presc_sel) + 3)) - 1;
        tick  = core_run && (m_pre >= lim);
        case (core_mode)
            2'd0:    evt = tick;
            2'd1:    evt = tick && (gate_in == gate_lvl);
            2'd2:    evt = core_run && cnt_in && !m_cq;
            default: evt = 1'b0;
        endcase
        cwrap  = evt && !core_wr && (core_up ? (m_core == 16'hFFFF) : (m_core == 16'h0));
        n_core = core_wr ? core_wdata : (evt ? (core_up ? m_core + 16'd1 : m_core - 16'd1) : m_core);
        n_tl   = tl_wr ? tl_wdata : (cwrap ? ~m_tl : m_tl);
        rise   = m_tl && !m_tlq;
        fall   = !m_tl && m_tlq;
        case (edge_sel)
            2'd0:    step = aux_run && rise;
            2'd1:    step = aux_run && fall;
            default: step = aux_run && (rise || fall);
        endcase
        awrap = step && !aux_wr && (aux_up ? (m_aux == 16'hFFFF) : (m_aux == 16'h0));
        n_aux = aux_wr ? aux_wdata : (step ? (aux_up ? m_aux + 16'd1 : m_aux - 16'd1) : m_aux);
        @(posedge clk);
        m_pre  = !core_run ? 0 : (tick ? 0 : m_pre + 1);
        m_cq   = cnt_in;
        m_tlq  = m_tl;
        m_core = n_core;
        m_tl   = n_tl;
        m_aux  = n_aux;
        m_cirq = cwrap;
        m_airq = awrap;
        e.core = m_core; e.aux = m_aux; e.tl = m_tl;
        e.cirq = m_cirq; e.airq = m_airq; e.req = cur_req;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    // monitor: compares each predicted cycle away from the clock edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            got = exp_q.pop_front();
            chk(core_val == got.core, got.req, "core_val", 32'(core_val), 32'(got.core));
            chk(aux_val == got.aux, got.req, "aux_val", 32'(aux_val), 32'(got.aux));
            chk(tl_q == got.tl, got.req, "tl_q", 32'(tl_q), 32'(got.tl));
            chk(core_irq == got.cirq, got.req, "core_irq", 32'(core_irq), 32'(got.cirq));
            chk(aux_irq == got.airq, got.req, "aux_irq", 32'(aux_irq), 32'(got.airq));
        end
    end

    task automatic pulse();
        cnt_in = 1'b1; cyc();
        cnt_in = 1'b0; cyc();
    endtask

    task automatic load_core(input logic [15:0] v);
        core_wr = 1'b1; core_wdata = v; cyc();
        core_wr = 1'b0;
    endtask

    task automatic load_aux(input logic [15:0] v);
        aux_wr = 1'b1; aux_wdata = v; cyc();
        aux_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(core_val == 16'h0 && aux_val == 16'h0, "R1", "counters", {core_val, aux_val}, 32'h0);
        chk(!tl_q && !core_irq && !aux_irq, "R1", "latch/irq", {29'h0, tl_q, core_irq, aux_irq}, 32'h0);
        rst_n = 1'b1;
        core_run = 1'b1; aux_run = 1'b1; core_mode = 2'd2; edge_sel = 2'd2;
        cyc();

        // R9 R2 R3 R4: counting external pulses up through the wrap
        cur_req = "R9";
        pulse(); pulse();
        cur_req = "R2";
        load_core(16'hFFFE);
        pulse(); pulse();
        chk(core_val == 16'h0 && tl_q == 1'b1, "R3", "core/latch after wrap", {core_val, 15'h0, tl_q}, 32'h0000_0001);
        chk(aux_val == 16'h1, "R4", "aux after one wrap", 32'(aux_val), 32'h1);

        // R5 rising-only: one step per two wraps
        cur_req = "R5"; edge_sel = 2'd0;
        load_aux(16'h0);
        for (int i = 0; i < 4; i++) begin
            load_core(16'hFFFF);
            pulse();
        end
        chk(aux_val == 16'h2, "R5", "aux rise-only after 4 wraps", 32'(aux_val), 32'h2);
        edge_sel = 2'd1;
        for (int i = 0; i < 4; i++) begin
            load_core(16'hFFFF);
            pulse();
        end
        chk(aux_val == 16'h4, "R5", "aux fall-only after 4 more wraps", 32'(aux_val), 32'h4);

        // R6 mixed and downward directions with aux wrap
        cur_req = "R6"; edge_sel = 2'd3; core_up = 1'b0; aux_up = 1'b0;
        load_aux(16'h0);
        load_core(16'h1);
        pulse(); pulse();
        chk(aux_val == 16'hFFFF && core_val == 16'hFFFF, "R6", "both down-wrapped", {core_val, aux_val}, 32'hFFFF_FFFF);
        aux_up = 1'b1;
        load_core(16'h0);
        pulse();
        core_up = 1'b1;

        // R10 core load coinciding with a count event
        cur_req = "R10";
        core_wr = 1'b1; core_wdata = 16'h1234; cnt_in = 1'b1; cyc();
        core_wr = 1'b0; cnt_in = 1'b0; cyc();
        chk(core_val == 16'h1234, "R10", "load beats count", 32'(core_val), 32'h1234);
        load_core(16'hFFFF);
        core_wr = 1'b1; core_wdata = 16'hFFFF; cnt_in = 1'b1; cyc();
        core_wr = 1'b0; cnt_in = 1'b0; cyc();

        // R11 aux load in the cycle its step is due
        cur_req = "R11";
        cnt_in = 1'b1; cyc();
        cnt_in = 1'b0; aux_wr = 1'b1; aux_wdata = 16'hABCD; cyc();
        aux_wr = 1'b0; cyc();
        chk(aux_val == 16'hABCD, "R11", "load beats step", 32'(aux_val), 32'hABCD);

        // R12 latch load coinciding with a wrap, then a plain latch load
        cur_req = "R12";
        load_core(16'hFFFF);
        tl_wr = 1'b1; tl_wdata = tl_q; cnt_in = 1'b1; cyc();
        tl_wr = 1'b0; cnt_in = 1'b0; cyc();
        tl_wr = 1'b1; tl_wdata = ~tl_q; cyc();
        tl_wr = 1'b0; cyc(); cyc();

        // R13 halted halves ignore their sources
        cur_req = "R13"; aux_run = 1'b0;
        for (int i = 0; i < 3; i++) begin
            load_core(16'hFFFF);
            pulse();
        end
        aux_run = 1'b1; core_run = 1'b0;
        pulse(); pulse();
        core_run = 1'b1;
        core_mode = 2'd3; cur_req = "R9";
        pulse(); pulse();

        // R7 divided clock, two ratios
        cur_req = "R7"; core_mode = 2'd0; presc_sel = 3'd0;
        core_run = 1'b0; cyc();
        load_core(16'hFFF8);
        core_run = 1'b1;
        repeat (80) cyc();
        core_run = 1'b0; presc_sel = 3'd1; cyc();
        core_run = 1'b1;
        repeat (70) cyc();

        // R8 gated by level
        cur_req = "R8"; core_mode = 2'd1; presc_sel = 3'd0; gate_lvl = 1'b1;
        for (int i = 0; i < 6; i++) begin
            gate_in = ~gate_in;
            repeat (13) cyc();
        end
        gate_lvl = 1'b0;
        repeat (30) cyc();
        gate_in = ~gate_in;
        repeat (30) cyc();

        cyc();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule